// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the slave-side serial interface of a 512K x 8 serial flash. It runs on the chip's system clock and oversamples the four serial pins (clock, active-low select, data in, data out). Each selection is framed into bytes, most significant bit first. The first byte is decoded as an opcode. The block serves three kinds of output command by itself: array read, status read and identification read. Array bytes are fetched through a byte-wide memory port that responds combinationally. The status byte comes from downstream logic.

Commands that change state are not executed here. Erase, program, write-enable, write-disable, power-down and power-down exit are handed downstream as a one-cycle strobe when select rises. The strobe carries the opcode, the 19-bit array address and the number of data bytes. Program data bytes are streamed downstream one at a time while they arrive. The block itself keeps only one piece of state across selections: the power-down state, which silences every command except the power-down exit.

The serial clock must be at most one eighth of the system clock, so that each serial half period spans at least four system cycles. The data-out pin is modelled as a value plus an output enable, not as a tri-state.

Top module: `spi_flash_front`

## Requirements
- R1: The serial clock level sampled when select falls picks the mode: low is mode 0 and high is mode 3. Both modes return identical data for the same command. In mode 3, the falling clock edge that comes before the first rising edge has no effect.
- R2: Opcode 03h, followed by three address bytes, returns array bytes starting at the next falling clock edge. The first byte comes from the given address, and the address advances by one for each byte. Address bits A23..A19 (byte 1, bits 7..3) are ignored.
- R3: Opcode 0Bh behaves as 03h, but one extra don't-care byte follows the address, and output starts one byte later.
- R4: A sequential read that passes address 7FFFFh continues at 00000h.
- R5: Opcode 05h returns the `status_in` byte, sampled anew for every byte, repeatedly for as long as the clock runs. It is accepted even when `status_in[0]` (busy) is 1.
- R6: Opcode 9Fh returns 62h, 11h, 00h and repeats that sequence. If `status_in[0]` is 1 when the opcode completes, the command is rejected and `spi_miso_oe` stays 0.
- R7: `spi_miso_oe` is 0 in all of these cases: while deselected, during opcode, address and dummy bytes, and for all opcodes other than 03h, 0Bh, 05h and 9Fh.
- R8: When select rises after a complete legal command, `cmd_valid` pulses for exactly one cycle, with `cmd_code` equal to the opcode. The minimum lengths are: 1 byte for 06h, 04h, C7h, B9h and ABh; 4 bytes for DBh and D8h; 5 bytes for 02h and 0Ah. For DBh, D8h, 02h and 0Ah, `cmd_addr` holds A18..A0.
- R9: No strobe is issued in two cases: when select rises at a bit count that is not a multiple of 8, or when the command is shorter than its minimum length.
- R10: For 02h and 0Ah, each complete byte after the address pulses `wr_valid` with that byte on `wr_byte`. The `cmd_count` value is the number of data bytes, capped at 256. Other commands give a count of 0.
- R11: A legal B9h enters power-down. In power-down every opcode except ABh gives no output and no strobe. ABh is strobed and leaves power-down.
- R12: After reset, `spi_miso_oe`, `cmd_valid` and `wr_valid` are 0, and the block is not in power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | Drive enable for `spi_miso` |
| mem_addr | output | 19 | Array byte address to read |
| mem_rdata | input | 8 | Array byte at `mem_addr` (combinational) |
| status_in | input | 8 | Status byte; bit 0 is busy |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_code | output | 8 | Opcode of the strobed command |
| cmd_addr | output | 19 | A18..A0 of the strobed command |
| cmd_count | output | 9 | Data byte count, capped at 256 |
| wr_valid | output | 1 | One-cycle pulse per program data byte |
| wr_byte | output | 8 | Program data byte |

## Verification
A wrong byte counter or bit counter moves the point where output starts, so the first returned byte is shifted, or `spi_miso_oe` rises early or late. This shows on the very next byte the master samples. A wrong read pointer or identification index corrupts the output stream within one byte, which is why the checks cover the wrap past 7FFFFh and the third repeat of the identification sequence. A wrong legality decision or a stale power-down flag is visible only at the rising edge of select, as a strobe that is missing, extra or carries the wrong count. Every transaction therefore ends with a comparison of the strobes and streamed data bytes captured from the ports.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

    localparam logic [7:0] OPC_READ   = 8'h03;
    localparam logic [7:0] OPC_FREAD  = 8'h0B;
    localparam logic [7:0] OPC_STATUS = 8'h05;
    localparam logic [7:0] OPC_IDENT  = 8'h9F;
    localparam logic [7:0] OPC_WEN    = 8'h06;
    localparam logic [7:0] OPC_WDIS   = 8'h04;
    localparam logic [7:0] OPC_SLEEP  = 8'hB9;
    localparam logic [7:0] OPC_WAKE   = 8'hAB;
    localparam logic [7:0] OPC_PERASE = 8'hDB;
    localparam logic [7:0] OPC_SERASE = 8'hD8;
    localparam logic [7:0] OPC_CERASE = 8'hC7;
    localparam logic [7:0] OPC_PPROG  = 8'h02;
    localparam logic [7:0] OPC_PWRITE = 8'h0A;

    localparam logic [7:0] IDENT_B0 = 8'h62;
    localparam logic [7:0] IDENT_B1 = 8'h11;
    localparam logic [7:0] IDENT_B2 = 8'h00;

    typedef enum logic [2:0] {
        K_NONE,
        K_READ,
        K_STATUS,
        K_IDENT,
        K_SHORT,
        K_ADDR,
        K_DATA
    } kind_e;

    function automatic kind_e classify(input logic [7:0] op);
        kind_e k;
        case (op)
            OPC_READ, OPC_FREAD:                       k = K_READ;
            OPC_STATUS:                                k = K_STATUS;
            OPC_IDENT:                                 k = K_IDENT;
            OPC_WEN, OPC_WDIS, OPC_SLEEP, OPC_WAKE,
            OPC_CERASE:                                k = K_SHORT;
            OPC_PERASE, OPC_SERASE:                    k = K_ADDR;
            OPC_PPROG, OPC_PWRITE:                     k = K_DATA;
            default:                                   k = K_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sck_s,
    output logic sck_rise,
    output logic sck_fall,
    output logic sel,
    output logic sel_start,
    output logic sel_end,
    output logic mosi_s
);
    typedef struct packed {
        logic [STAGES-1:0] sck;
        logic [STAGES-1:0] csn;
        logic [STAGES-1:0] mosi;
        logic              sck_prev;
        logic              sel_prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d          = q;
        d.sck      = {q.sck[STAGES-2:0], sck_i};
        d.csn      = {q.csn[STAGES-2:0], cs_n_i};
        d.mosi     = {q.mosi[STAGES-2:0], mosi_i};
        d.sck_prev = q.sck[STAGES-1];
        d.sel_prev = ~q.csn[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sck      <= '0;
            q.csn      <= '1;
            q.mosi     <= '0;
            q.sck_prev <= 1'b0;
            q.sel_prev <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sck_s     = q.sck[STAGES-1];
    assign sck_rise  = sck_s & ~q.sck_prev;
    assign sck_fall  = ~sck_s & q.sck_prev;
    assign sel       = ~q.csn[STAGES-1];
    assign sel_start = sel & ~q.sel_prev;
    assign sel_end   = ~sel & q.sel_prev;
    assign mosi_s    = q.mosi[STAGES-1];

endmodule

// File: rtl/spi_fe_rx.sv
module spi_fe_rx #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             sel_start,
    input  logic             sck_s,
    input  logic             sck_rise,
    input  logic             sck_fall,
    input  logic             mosi_s,
    output logic [7:0]       rx_byte,
    output logic             rx_valid,
    output logic [CNT_W-1:0] rx_idx,
    output logic [2:0]       bit_cnt,
    output logic [CNT_W-1:0] nbytes,
    output logic             fall_ok
);
    typedef struct packed {
        logic [7:0]       sr;
        logic [2:0]       bitc;
        logic [CNT_W-1:0] nb;
        logic             mode3;
        logic             seen_rise;
        logic [7:0]       vbyte;
        logic             valid;
        logic [CNT_W-1:0] idx;
    } rx_t;

    rx_t q, d;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        if (sel_start) begin
            d.sr        = '0;
            d.bitc      = '0;
            d.nb        = '0;
            d.mode3     = sck_s;
            d.seen_rise = 1'b0;
        end else if (sel && sck_rise) begin
            d.sr        = {q.sr[6:0], mosi_s};
            d.bitc      = q.bitc + 3'd1;
            d.seen_rise = 1'b1;
            if (q.bitc == 3'd7) begin
                d.valid = 1'b1;
                d.vbyte = {q.sr[6:0], mosi_s};
                d.idx   = q.nb;
                if (q.nb != '1) begin
                    d.nb = q.nb + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rx_byte  = q.vbyte;
    assign rx_valid = q.valid;
    assign rx_idx   = q.idx;
    assign bit_cnt  = q.bitc;
    assign nbytes   = q.nb;
    // in mode 3 the opening falling edge precedes any data and is dropped
    assign fall_ok  = sel & sck_fall & (q.seen_rise | ~q.mode3);

    // a completed byte is always reported while still selected
    p_byte_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(sel));

endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       shift,
    output logic       miso,
    output logic       miso_oe
);
    typedef struct packed {
        logic [7:0] sr;
        logic       oe;
    } tx_t;

    tx_t q, d;

    always_comb begin
        d = q;
        if (!sel) begin
            d.oe = 1'b0;
        end else if (load) begin
            d.sr = load_byte;
            d.oe = 1'b1;
        end else if (shift && q.oe) begin
            d.sr = {q.sr[6:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign miso    = q.sr[7];
    assign miso_oe = q.oe;

    p_oe_off_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !miso_oe);

    p_load_only_selected_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> sel);

endmodule

// File: rtl/spi_fe_ctrl.sv
module spi_fe_ctrl
    import spi_fe_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int MAX_DATA = 256,
    parameter int CNT_W    = 10,
    parameter int DCNT_W   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_start,
    input  logic              sel_end,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic [CNT_W-1:0]  rx_idx,
    input  logic [2:0]        bit_cnt,
    input  logic [CNT_W-1:0]  nbytes,
    input  logic              fall_ok,
    input  logic [7:0]        mem_rdata,
    input  logic [7:0]        status_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              tx_load,
    output logic [7:0]        tx_byte,
    output logic              cmd_valid,
    output logic [7:0]        cmd_code,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DCNT_W-1:0] cmd_count,
    output logic              wr_valid,
    output logic [7:0]        wr_byte
);
    localparam int HDR_BYTES = 4;
    localparam logic [CNT_W-1:0] HDR_N = CNT_W'(HDR_BYTES);
    localparam logic [CNT_W-1:0] CAP_N = CNT_W'(MAX_DATA);

    typedef struct packed {
        logic [7:0]        op;
        kind_e             kind;
        logic              out_en;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] ptr;
        logic [1:0]        id_sel;
        logic              pd;
        logic              cmd_valid;
        logic [7:0]        cmd_code;
        logic [ADDR_W-1:0] cmd_addr;
        logic [DCNT_W-1:0] cmd_count;
        logic              wr_valid;
        logic [7:0]        wr_byte;
    } ctl_t;

    ctl_t q, d;

    logic [CNT_W-1:0] first_out;
    logic [CNT_W-1:0] min_len;
    logic [CNT_W-1:0] data_n;
    logic             writeish;
    kind_e            new_kind;

    always_comb begin
        case (q.kind)
            K_READ:  first_out = (q.op == OPC_FREAD) ? HDR_N + 1'b1 : HDR_N;
            default: first_out = CNT_W'(1);
        endcase
        case (q.kind)
            K_ADDR:  min_len = HDR_N;
            K_DATA:  min_len = HDR_N + 1'b1;
            default: min_len = CNT_W'(1);
        endcase
        writeish = (q.kind == K_SHORT) || (q.kind == K_ADDR) || (q.kind == K_DATA);
        data_n   = nbytes - HDR_N;
        new_kind = classify(rx_byte);
        if (q.pd && (rx_byte != OPC_WAKE)) begin
            new_kind = K_NONE;
        end
    end

    always_comb begin
        d           = q;
        d.cmd_valid = 1'b0;
        d.wr_valid  = 1'b0;
        tx_load     = 1'b0;
        tx_byte     = 8'h00;

        if (sel_start) begin
            d.op     = 8'h00;
            d.kind   = K_NONE;
            d.out_en = 1'b0;
            d.id_sel = 2'd0;
        end

        if (rx_valid) begin
            if (rx_idx == '0) begin
                d.op     = rx_byte;
                d.kind   = new_kind;
                d.out_en = (new_kind == K_READ) || (new_kind == K_STATUS) ||
                           ((new_kind == K_IDENT) && !status_in[0]);
                d.id_sel = 2'd0;
            end else if (rx_idx == CNT_W'(1)) begin
                d.addr[ADDR_W-1:16] = rx_byte[ADDR_W-17:0];
            end else if (rx_idx == CNT_W'(2)) begin
                d.addr[15:8] = rx_byte;
            end else if (rx_idx == CNT_W'(3)) begin
                d.addr[7:0] = rx_byte;
                d.ptr       = {q.addr[ADDR_W-1:8], rx_byte};
            end else if (q.kind == K_DATA) begin
                d.wr_valid = 1'b1;
                d.wr_byte  = rx_byte;
            end
        end

        if (fall_ok && (bit_cnt == 3'd0) && q.out_en && (nbytes >= first_out)) begin
            tx_load = 1'b1;
            case (q.kind)
                K_READ: begin
                    tx_byte = mem_rdata;
                    d.ptr   = q.ptr + 1'b1;
                end
                K_STATUS: begin
                    tx_byte = status_in;
                end
                K_IDENT: begin
                    case (q.id_sel)
                        2'd0:    tx_byte = IDENT_B0;
                        2'd1:    tx_byte = IDENT_B1;
                        default: tx_byte = IDENT_B2;
                    endcase
                    d.id_sel = (q.id_sel == 2'd2) ? 2'd0 : q.id_sel + 2'd1;
                end
                default: tx_load = 1'b0;
            endcase
        end

        if (sel_end) begin
            if (writeish && (bit_cnt == 3'd0) && (nbytes >= min_len)) begin
                d.cmd_valid = 1'b1;
                d.cmd_code  = q.op;
                d.cmd_addr  = q.addr;
                if (q.kind == K_DATA) begin
                    d.cmd_count = (data_n > CAP_N) ? DCNT_W'(MAX_DATA) : DCNT_W'(data_n);
                end else begin
                    d.cmd_count = '0;
                end
                if (q.op == OPC_SLEEP) d.pd = 1'b1;
                if (q.op == OPC_WAKE)  d.pd = 1'b0;
            end
            d.kind   = K_NONE;
            d.out_en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.kind <= K_NONE;
        end else begin
            q <= d;
        end
    end

    assign mem_addr  = q.ptr;
    assign cmd_valid = q.cmd_valid;
    assign cmd_code  = q.cmd_code;
    assign cmd_addr  = q.cmd_addr;
    assign cmd_count = q.cmd_count;
    assign wr_valid  = q.wr_valid;
    assign wr_byte   = q.wr_byte;

    p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    p_strobe_at_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(sel_end));

    p_count_capped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_count <= DCNT_W'(MAX_DATA)));

    p_wr_only_program_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ((q.op == OPC_PPROG) || (q.op == OPC_PWRITE)));

    p_sleep_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        q.pd |-> !tx_load);

    p_read_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load && (q.kind == K_READ)) |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

endmodule

// File: rtl/spi_flash_front.sv
module spi_flash_front #(
    parameter  int ADDR_W      = 19,
    parameter  int MAX_DATA    = 256,
    parameter  int SYNC_STAGES = 2,
    localparam int DCNT_W      = $clog2(MAX_DATA + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    input  logic [7:0]        status_in,
    output logic              cmd_valid,
    output logic [7:0]        cmd_code,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DCNT_W-1:0] cmd_count,
    output logic              wr_valid,
    output logic [7:0]        wr_byte
);
    localparam int CNT_W = $clog2(MAX_DATA + 8) + 1;

    logic             sck_s, sck_rise, sck_fall, sel, sel_start, sel_end, mosi_s;
    logic [7:0]       rx_byte;
    logic             rx_valid;
    logic [CNT_W-1:0] rx_idx;
    logic [2:0]       bit_cnt;
    logic [CNT_W-1:0] nbytes;
    logic             fall_ok;
    logic             tx_load;
    logic [7:0]       tx_byte;

    spi_fe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_i    (spi_sck),
        .cs_n_i   (spi_cs_n),
        .mosi_i   (spi_mosi),
        .sck_s    (sck_s),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .sel      (sel),
        .sel_start(sel_start),
        .sel_end  (sel_end),
        .mosi_s   (mosi_s)
    );

    spi_fe_rx #(.CNT_W(CNT_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .sel_start(sel_start),
        .sck_s    (sck_s),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .mosi_s   (mosi_s),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid),
        .rx_idx   (rx_idx),
        .bit_cnt  (bit_cnt),
        .nbytes   (nbytes),
        .fall_ok  (fall_ok)
    );

    spi_fe_ctrl #(
        .ADDR_W  (ADDR_W),
        .MAX_DATA(MAX_DATA),
        .CNT_W   (CNT_W),
        .DCNT_W  (DCNT_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_start(sel_start),
        .sel_end  (sel_end),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .rx_idx   (rx_idx),
        .bit_cnt  (bit_cnt),
        .nbytes   (nbytes),
        .fall_ok  (fall_ok),
        .mem_rdata(mem_rdata),
        .status_in(status_in),
        .mem_addr (mem_addr),
        .tx_load  (tx_load),
        .tx_byte  (tx_byte),
        .cmd_valid(cmd_valid),
        .cmd_code (cmd_code),
        .cmd_addr (cmd_addr),
        .cmd_count(cmd_count),
        .wr_valid (wr_valid),
        .wr_byte  (wr_byte)
    );

    spi_fe_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .load     (tx_load),
        .load_byte(tx_byte),
        .shift    (fall_ok),
        .miso     (spi_miso),
        .miso_oe  (spi_miso_oe)
    );

endmodule

// File: tb/tb_spi_flash_front.sv
module tb_spi_flash_front;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic [7:0]  status_in = 8'h00;
    logic        miso, miso_oe, cmd_valid, wr_valid;
    logic [18:0] mem_addr, cmd_addr;
    logic [7:0]  mem_rdata, cmd_code, wr_byte;
    logic [8:0]  cmd_count;

    int checks = 0;
    int errors = 0;

    logic [7:0]  tx_q[$];
    logic [7:0]  rx_q[$];
    bit          oe_q[$];
    logic [7:0]  sc_code[$];
    logic [18:0] sc_addr[$];
    int          sc_cnt[$];
    logic [7:0]  wr_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] memf(input logic [18:0] a);
        return a[7:0] ^ a[15:8] ^ {5'd0, a[18:16]} ^ 8'h5A;
    endfunction

    assign mem_rdata = memf(mem_addr);

    spi_flash_front dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(miso_oe), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .status_in(status_in), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_addr(cmd_addr), .cmd_count(cmd_count), .wr_valid(wr_valid), .wr_byte(wr_byte)
    );

    // port monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (cmd_valid) begin
            sc_code.push_back(cmd_code);
            sc_addr.push_back(cmd_addr);
            sc_cnt.push_back(int'(cmd_count));
        end
        if (wr_valid) wr_q.push_back(wr_byte);
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one selection; drop_bits removes trailing bits of the last byte
    task automatic txn(input bit m3, input int drop_bits);
        int total;
        logic [7:0] cur;
        rx_q.delete(); oe_q.delete(); wr_q.delete();
        sc_code.delete(); sc_addr.delete(); sc_cnt.delete();
        total = tx_q.size() * 8 - drop_bits;
        cur = 8'h00;
        sck = m3;
        wait_clk(4);
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int b = 0; b < total; b++) begin
            sck  = 1'b0;
            mosi = tx_q[b / 8][7 - (b % 8)];
            wait_clk(HALF);
            if ((b % 8) == 0) oe_q.push_back(miso_oe);
            cur = {cur[6:0], miso};
            sck = 1'b1;
            wait_clk(HALF);
            if ((b % 8) == 7) rx_q.push_back(cur);
        end
        if (!m3) sck = 1'b0;
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic send_read(input bit m3, input logic [7:0] op, input logic [23:0] a, input int n);
        tx_q.delete();
        tx_q.push_back(op);
        tx_q.push_back(a[23:16]); tx_q.push_back(a[15:8]); tx_q.push_back(a[7:0]);
        for (int i = 0; i < n; i++) tx_q.push_back(8'h00);
        txn(m3, 0);
    endtask

    task automatic chk_read(input string tag, input logic [18:0] a, input int start);
        for (int i = 0; i < rx_q.size(); i++) begin
            if (i < start) begin
                chk({tag, " header oe"}, 32'(oe_q[i]), 32'd0);
            end else begin
                chk({tag, " data oe"}, 32'(oe_q[i]), 32'd1);
                chk({tag, " data"}, 32'(rx_q[i]), 32'(memf(a + 19'(i - start))));
            end
        end
    endtask

    task automatic chk_silent(input string tag);
        for (int i = 0; i < oe_q.size(); i++) chk({tag, " oe"}, 32'(oe_q[i]), 32'd0);
    endtask

    task automatic chk_strobe(input string tag, input int n, input logic [7:0] code,
                              input logic [18:0] a, input bit use_a, input int cnt);
        chk({tag, " strobe count"}, 32'(sc_code.size()), 32'(n));
        if (n == 1 && sc_code.size() == 1) begin
            chk({tag, " code"}, 32'(sc_code[0]), 32'(code));
            if (use_a) chk({tag, " addr"}, 32'(sc_addr[0]), 32'(a));
            chk({tag, " data count"}, 32'(sc_cnt[0]), 32'(cnt));
        end
    endtask

    task automatic one_byte(input bit m3, input logic [7:0] op, input int drop);
        tx_q.delete();
        tx_q.push_back(op);
        txn(m3, drop);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        // R12 reset state
        chk("R12 oe after reset", 32'(miso_oe), 32'd0);
        chk("R12 strobe after reset", 32'(cmd_valid), 32'd0);
        chk("R12 wr after reset", 32'(wr_valid), 32'd0);

        // R2 / R1: read in mode 0, high address bits ignored
        send_read(1'b0, 8'h03, 24'hF12345, 6);
        chk_read("R2 read mode0", 19'h12345, 4);
        chk_strobe("R7 read no strobe", 0, 8'h00, '0, 1'b0, 0);
        // R1: identical read in mode 3
        send_read(1'b1, 8'h03, 24'hF12345, 6);
        chk_read("R1 read mode3", 19'h12345, 4);

        // R3 fast read with dummy byte
        send_read(1'b1, 8'h0B, 24'h0000F0, 5);
        chk_read("R3 fast read", 19'h000F0, 5);

        // R4 wrap past top address
        send_read(1'b0, 8'h03, 24'h07FFFE, 5);
        chk_read("R4 wrap", 19'h7FFFE, 4);

        // R5 status repeats while busy
        status_in = 8'hA5;
        tx_q.delete(); tx_q.push_back(8'h05);
        for (int i = 0; i < 3; i++) tx_q.push_back(8'h00);
        txn(1'b0, 0);
        chk("R5 opcode oe", 32'(oe_q[0]), 32'd0);
        for (int i = 1; i < 4; i++) begin
            chk("R5 status oe", 32'(oe_q[i]), 32'd1);
            chk("R5 status byte", 32'(rx_q[i]), 32'hA5);
        end

        // R6 identification stream, idle
        status_in = 8'h00;
        tx_q.delete(); tx_q.push_back(8'h9F);
        for (int i = 0; i < 7; i++) tx_q.push_back(8'h00);
        txn(1'b1, 0);
        for (int i = 1; i < 8; i++) begin
            chk("R6 id oe", 32'(oe_q[i]), 32'd1);
            case ((i - 1) % 3)
                0: chk("R6 id byte", 32'(rx_q[i]), 32'h62);
                1: chk("R6 id byte", 32'(rx_q[i]), 32'h11);
                default: chk("R6 id byte", 32'(rx_q[i]), 32'h00);
            endcase
        end
        // R6 rejected while busy
        status_in = 8'h01;
        tx_q.delete(); tx_q.push_back(8'h9F);
        for (int i = 0; i < 3; i++) tx_q.push_back(8'h00);
        txn(1'b0, 0);
        chk_silent("R6 id busy");
        status_in = 8'h00;

        // R8 short command, R7 no output
        one_byte(1'b0, 8'h06, 0);
        chk_strobe("R8 write enable", 1, 8'h06, '0, 1'b0, 0);
        chk_silent("R7 write enable");
        // R8 address command, upper bits dropped
        tx_q.delete();
        tx_q.push_back(8'hD8); tx_q.push_back(8'h0A); tx_q.push_back(8'h12); tx_q.push_back(8'h34);
        txn(1'b1, 0);
        chk_strobe("R8 sector erase", 1, 8'hD8, 19'h21234, 1'b1, 0);

        // R9 truncations
        one_byte(1'b0, 8'h06, 1);
        chk_strobe("R9 seven bits", 0, 8'h00, '0, 1'b0, 0);
        tx_q.delete(); tx_q.push_back(8'hDB); tx_q.push_back(8'h00); tx_q.push_back(8'h01);
        txn(1'b0, 0);
        chk_strobe("R9 short erase", 0, 8'h00, '0, 1'b0, 0);
        send_read(1'b1, 8'h02, 24'h001200, 0);
        chk_strobe("R9 program no data", 0, 8'h00, '0, 1'b0, 0);
        send_read(1'b0, 8'h02, 24'h001200, 2);
        tx_q.delete();
        tx_q.push_back(8'h02); tx_q.push_back(8'h00); tx_q.push_back(8'h12);
        tx_q.push_back(8'h00); tx_q.push_back(8'h77); tx_q.push_back(8'h55);
        txn(1'b0, 5);
        chk_strobe("R9 partial data byte", 0, 8'h00, '0, 1'b0, 0);

        // R10 program with three data bytes
        tx_q.delete();
        tx_q.push_back(8'h02); tx_q.push_back(8'h00); tx_q.push_back(8'h12); tx_q.push_back(8'h40);
        tx_q.push_back(8'hC3); tx_q.push_back(8'h3C); tx_q.push_back(8'h99);
        txn(1'b0, 0);
        chk_strobe("R10 program", 1, 8'h02, 19'h01240, 1'b1, 3);
        chk("R10 wr bytes", 32'(wr_q.size()), 32'd3);
        if (wr_q.size() == 3) chk("R10 wr last", 32'(wr_q[2]), 32'h99);
        chk_silent("R7 program");

        // R10 page write beyond the cap
        tx_q.delete();
        tx_q.push_back(8'h0A); tx_q.push_back(8'h03); tx_q.push_back(8'h00); tx_q.push_back(8'h10);
        for (int i = 0; i < 258; i++) tx_q.push_back(8'(i * 7 + 3));
        txn(1'b1, 0);
        chk_strobe("R10 page write cap", 1, 8'h0A, 19'h30010, 1'b1, 256);
        chk("R10 wr stream length", 32'(wr_q.size()), 32'd258);
        if (wr_q.size() == 258) chk("R10 wr stream tail", 32'(wr_q[257]), 32'(8'(257 * 7 + 3)));

        // R7 unknown opcode
        send_read(1'b0, 8'h77, 24'h000000, 2);
        chk_silent("R7 unknown opcode");
        chk_strobe("R7 unknown opcode", 0, 8'h00, '0, 1'b0, 0);

        // R11 power-down
        one_byte(1'b1, 8'hB9, 0);
        chk_strobe("R11 enter sleep", 1, 8'hB9, '0, 1'b0, 0);
        send_read(1'b0, 8'h03, 24'h000100, 3);
        chk_silent("R11 read while asleep");
        one_byte(1'b0, 8'h06, 0);
        chk_strobe("R11 ignored while asleep", 0, 8'h00, '0, 1'b0, 0);
        one_byte(1'b0, 8'hAB, 0);
        chk_strobe("R11 wake", 1, 8'hAB, '0, 1'b0, 0);
        send_read(1'b1, 8'h03, 24'h000100, 3);
        chk_read("R11 read after wake", 19'h00100, 4);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule